// File: doc/BRIEF.md
# Three-Source Interrupt Status Controller

This block collects interrupt events for an external memory controller and presents them to software through four word-addressed registers on a simple synchronous bus. It handles three sources. The first is a rising edge on the external wait pin, which the block synchronizes and edge-detects itself. The second is an access timeout and the third is an unsupported addressing mode; each of these arrives as a one-cycle pulse from surrounding logic.

Each source has a raw status flag that records every event. It also has a separate masked status flag, which is captured only when the event fires while that source is enabled. Software clears both flags together by writing a one to the raw flag. Enables are turned on and off through a write-one-to-set window and a write-one-to-clear window. One registered interrupt line is the OR of the masked flags.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: A source event sets its raw flag whether or not that source is enabled. Bit 0 is the addressing-mode event, bit 1 is the timeout and bit 2 is the wait-rise event. The raw register is at offset 0x0.
- R3: Writing 1 to a raw bit at 0x0 clears that raw bit and also its masked bit. Writing 0 to a raw bit changes nothing.
- R4: A masked bit, read at 0x4, becomes set only when its event occurs while its enable is on.
- R5: Writing 1 to a bit at 0x8 turns that source's enable on. Reading 0x8 or 0xC returns the enable bits. Writing 0 there changes nothing.
- R6: Writing 1 to a bit at 0xC turns that source's enable off. Writing 0 there changes nothing.
- R7: Writes to the masked register at 0x4 are ignored.
- R8: The wait pin passes through two synchronizer flops. A low-to-high change sets raw bit 2 within four clock edges. A pin that stays high raises no further event.
- R9: When an event and a write-one-to-clear of its bit occur in the same cycle, the bit stays set.
- R10: `irq` is the registered OR of the masked bits, so it follows them one clock later. Turning an enable off leaves already-set masked bits, and so `irq`, unchanged.
- R11: Register bits above bit 2 read as 0 and have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wait_pin | input | 1 | External wait signal, asynchronous |
| timeout_evt | input | 1 | One-cycle timeout event pulse |
| trap_evt | input | 1 | One-cycle unsupported-addressing event pulse |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the timeout and addressing-mode inputs are already synchronous to `clk`. They also assume that a bus write lasts one cycle and targets one register, so a set and a clear of the same enable never coincide. The stimulus drives every input on the falling edge and holds each write strobe for one cycle. It only changes the wait pin with a few cycles between transitions, so the synchronizer sees clean levels.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned N_SRC = 3;

  localparam int unsigned SRC_TRAP    = 0;
  localparam int unsigned SRC_TIMEOUT = 1;
  localparam int unsigned SRC_WAIT    = 2;

  typedef enum logic [1:0] {
    REG_RAW  = 2'd0,
    REG_MASK = 2'd1,
    REG_ESET = 2'd2,
    REG_ECLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], async_in};
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = level & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic raw_clr,
  input  logic en_set,
  input  logic en_clr,
  output logic raw,
  output logic masked,
  output logic en
);
  logic raw_q, raw_d;
  logic msk_q, msk_d;
  logic en_q,  en_d;

  always_comb begin
    raw_d = raw_q;
    msk_d = msk_q;
    en_d  = en_q;
    if (raw_clr) begin
      raw_d = 1'b0;
      msk_d = 1'b0;
    end
    if (evt) begin
      raw_d = 1'b1;
      if (en_q) msk_d = 1'b1;
    end
    if (en_set)      en_d = 1'b1;
    else if (en_clr) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      msk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      msk_q <= msk_d;
      en_q  <= en_d;
    end
  end

  assign raw    = raw_q;
  assign masked = msk_q;
  assign en     = en_q;

  AST_RAW_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> raw); // R2
  AST_MASK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(masked) |-> $past(evt && en)); // R4
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_clr && !evt) |=> (!raw && !masked)); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_clr && evt) |=> raw); // R9
  AST_MASK_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> raw); // R3
  AST_DISABLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && masked && !raw_clr) |=> masked); // R10
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_pin,
  input  logic              timeout_evt,
  input  logic              trap_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic             rst_int_n;
  logic             wait_rise;
  logic [N_SRC-1:0] evt_vec;
  logic [N_SRC-1:0] raw_vec;
  logic [N_SRC-1:0] msk_vec;
  logic [N_SRC-1:0] en_vec;
  reg_sel_e         sel;
  logic             wr_raw, wr_eset, wr_eclr;
  logic             irq_q, irq_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_edge_sync #(.SYNC_STAGES(2)) u_wait (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (wait_pin),
    .rise     (wait_rise)
  );

  always_comb begin
    evt_vec              = '0;
    evt_vec[SRC_TRAP]    = trap_evt;
    evt_vec[SRC_TIMEOUT] = timeout_evt;
    evt_vec[SRC_WAIT]    = wait_rise;
  end

  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign wr_raw  = bus_we && (sel == REG_RAW);
  assign wr_eset = bus_we && (sel == REG_ESET);
  assign wr_eclr = bus_we && (sel == REG_ECLR);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .evt     (evt_vec[i]),
      .raw_clr (wr_raw  & bus_wdata[i]),
      .en_set  (wr_eset & bus_wdata[i]),
      .en_clr  (wr_eclr & bus_wdata[i]),
      .raw     (raw_vec[i]),
      .masked  (msk_vec[i]),
      .en      (en_vec[i])
    );
  end

  always_comb begin
    irq_d = |msk_vec;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq = irq_q;

  always_comb begin
    unique case (sel)
      REG_RAW:  bus_rdata = {{PAD_W{1'b0}}, raw_vec};
      REG_MASK: bus_rdata = {{PAD_W{1'b0}}, msk_vec};
      default:  bus_rdata = {{PAD_W{1'b0}}, en_vec};
    endcase
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|msk_vec) |=> irq); // R10
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(|msk_vec) |=> !irq); // R10
  AST_MASK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && sel == REG_MASK && !(|evt_vec)) |=> $stable(msk_vec)); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rdata[DATA_W-1:N_SRC] == '0); // R11
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wait_pin;
  logic              timeout_evt;
  logic              trap_evt;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .wait_pin(wait_pin), .timeout_evt(timeout_evt),
    .trap_evt(trap_evt), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_timeout();
    @(negedge clk); timeout_evt = 1'b1;
    @(negedge clk); timeout_evt = 1'b0;
  endtask

  task automatic pulse_trap();
    @(negedge clk); trap_evt = 1'b1;
    @(negedge clk); trap_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1", "raw after reset", v, 0);
    rd(4'h4, v); chk("R1", "masked after reset", v, 0);
    rd(4'h8, v); chk("R1", "enable after reset", v, 0);
    chk("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_raw_disabled();
    logic [31:0] v;
    pulse_timeout();
    rd(4'h0, v); chk("R2", "raw after timeout, disabled", v, 32'h2);
    rd(4'h4, v); chk("R4", "masked stays clear when disabled", v, 0);
    @(negedge clk);
    chk("R10", "irq low with no masked bit", irq, 0);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R3", "zero write to raw keeps bit", v, 32'h2);
    wr(4'h4, 32'h7);
    rd(4'h4, v); chk("R7", "masked write ignored", v, 0);
    rd(4'h0, v); chk("R7", "masked write leaves raw", v, 32'h2);
    wr(4'h0, 32'h2);
    rd(4'h0, v); chk("R3", "raw cleared by W1C", v, 0);
  endtask

  task automatic t_enable_path();
    logic [31:0] v;
    wr(4'h8, 32'h5);
    rd(4'h8, v); chk("R5", "enable via set window", v, 32'h5);
    rd(4'hC, v); chk("R5", "enable via clear window", v, 32'h5);
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R5", "zero write to set window", v, 32'h5);
    pulse_trap();
    rd(4'h0, v); chk("R2", "raw after trap", v, 32'h1);
    rd(4'h4, v); chk("R4", "masked after enabled trap", v, 32'h1);
    @(negedge clk);
    chk("R10", "irq raised", irq, 1);
    wr(4'hC, 32'h0);
    rd(4'hC, v); chk("R6", "zero write to clear window", v, 32'h5);
    wr(4'hC, 32'h1);
    rd(4'h8, v); chk("R6", "enable cleared", v, 32'h4);
    rd(4'h4, v); chk("R10", "masked kept after disable", v, 32'h1);
    chk("R10", "irq kept after disable", irq, 1);
    wr(4'h0, 32'h1);
    rd(4'h0, v); chk("R3", "raw cleared", v, 0);
    rd(4'h4, v); chk("R3", "masked cleared with raw", v, 0);
    @(negedge clk);
    chk("R10", "irq dropped", irq, 0);
    wr(4'h8, 32'hFFFF_FFF8);
    rd(4'h8, v); chk("R11", "upper bits no effect", v, 32'h4);
  endtask

  task automatic t_wait_edge();
    logic [31:0] v;
    @(negedge clk); wait_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h0, v); chk("R8", "raw after wait rise", v, 32'h4);
    rd(4'h4, v); chk("R8", "masked after wait rise", v, 32'h4);
    wr(4'h0, 32'h4);
    repeat (5) @(negedge clk);
    rd(4'h0, v); chk("R8", "held high gives no new event", v, 0);
    wait_pin = 1'b0;
    repeat (4) @(negedge clk);
    wait_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h0, v); chk("R8", "second rise detected", v, 32'h4);
    wr(4'h0, 32'h4);
    wait_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    pulse_timeout();
    @(negedge clk);
    timeout_evt = 1'b1;
    bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    timeout_evt = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    rd(4'h0, v); chk("R9", "event beats clear", v, 32'h2);
    wr(4'h0, 32'h2);
    rd(4'h0, v); chk("R3", "later clear works", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; wait_pin = 1'b0; timeout_evt = 1'b0; trap_evt = 1'b0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw_disabled();
    t_enable_path();
    t_wait_edge();
    t_priority();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule